// File: doc/BRIEF.md
# Event-Synchronized Buffered GPIO Controller

This block drives sixteen pads. Each pad has its own output enable and output value. The host can change the enables and values in two ways. It can write a live register, which acts on the pads one cycle later. It can also write a shadow buffer, which waits for a pulse from timer event A and then acts on every affected pad in the same cycle. Either kind of write can set bits or toggle them. A pending buffer carries a dirty flag. If the host writes to a buffer that is still pending, the write is stalled until the buffer has been committed, so no buffered update is ever lost.

On the input side, the pads are captured into an input register. One of four sampling policies applies: follow the pads every cycle, latch them on a pulse from timer event B, shift one chosen pad serially into the register on that pulse, or hold the register. While in the follow-every-cycle policy, any change on pad 0 raises a one-cycle wake pulse. The host can also make a synchronised read. That read stalls until the next event B pulse has refreshed the register.

Top module: `evt_gpio_ctrl`

## Requirements
- R1: While reset is asserted, and in the two cycles after it is released, `pad_oe`, `pad_out`, `in_data`, `dir_dirty`, `out_dirty` and `wake` are all zero.
- R2: A write with `wr_sel` 0 (enable set), 1 (enable toggle), 2 (value set) or 3 (value toggle) acts on the live register. A set replaces the register and a toggle XORs `wr_data` into it. The result appears on `pad_oe` or `pad_out` after the clock edge that takes the write.
- R3: A write with `wr_sel` 4 to 7 behaves like 0 to 3, but it goes to the matching shadow buffer. It sets `dir_dirty` (for 4 and 5) or `out_dirty` (for 6 and 7) and leaves the pads unchanged. On the next `ev0` pulse, the buffer replaces the live register (set) or is XORed into it (toggle), and the dirty flag clears.
- R4: A buffered write to a buffer whose dirty flag is set raises `wr_stall` in the same cycle. The write is not taken and the pads do not change. The write is taken in the first cycle after the commit.
- R5: A live write also loads its buffer and clears its dirty flag. It takes priority over an `ev0` pulse in the same cycle. A later `ev0` pulse then changes nothing.
- R6: With `in_mode` 0, `in_data` equals the `pad_in` value from the previous clock edge.
- R7: With `in_mode` 1, `in_data` changes only on an `ev1` pulse, when it loads `pad_in`.
- R8: With `in_mode` 2, on an `ev1` pulse `in_data` shifts one place toward bit 15 and takes `pad_in[SHIFT_PIN]` (default pin 1) into bit 0. Without an `ev1` pulse, `in_data` holds.
- R9: With `in_mode` 3, `in_data` holds whatever the pads and event pulses do.
- R10: With `in_mode` 0, a change of `pad_in[0]` gives a `wake` pulse exactly one cycle long, after the edge that sees the change. In the other modes, `wake` stays low.
- R11: While `in_rd_buf` is high, `in_stall` stays high until the cycle after an `ev1` pulse. In that cycle, `in_stall` is low and `in_data` holds the freshly captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write request |
| wr_sel | input | 3 | Target: bit 2 selects the buffer, bit 1 selects the value register (not the enable), bit 0 selects toggle |
| wr_data | input | 16 | Write data |
| wr_stall | output | 1 | Buffered write held off because the buffer is pending |
| dir_dirty | output | 1 | Enable buffer pending |
| out_dirty | output | 1 | Value buffer pending |
| ev0 | input | 1 | Timer event A pulse (commits the buffers) |
| ev1 | input | 1 | Timer event B pulse (samples the inputs) |
| in_mode | input | 2 | Input policy: 0 follow, 1 latch, 2 shift, 3 hold |
| in_rd_buf | input | 1 | Synchronised input read request |
| in_stall | output | 1 | Synchronised read waiting for event B |
| in_data | output | 16 | Input register |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| wake | output | 1 | Pin-0 change pulse |

## Verification
The hardest state to reach is a buffered write that is already stalled at the moment the `ev0` pulse commits the pending buffer. The write must then land exactly one cycle later and must not be lost or doubled. The bench fills the value buffer and holds a second buffered write on the port across several cycles. It pulses `ev0` while that request is still asserted, then checks the pads after the commit and again after a second pulse. A live write in the same cycle as `ev0` with a pending buffer is driven in the same directed way.

// File: rtl/evt_gpio_pkg.sv
package evt_gpio_pkg;
  localparam int unsigned NPINS = 16;

  typedef enum logic [1:0] {
    IN_FOLLOW = 2'd0,
    IN_LATCH  = 2'd1,
    IN_SHIFT  = 2'd2,
    IN_HOLD   = 2'd3
  } in_mode_e;

  // wr_sel fields
  localparam int unsigned SEL_BUF_BIT = 2;
  localparam int unsigned SEL_VAL_BIT = 1;
  localparam int unsigned SEL_TGL_BIT = 0;
endpackage

// File: rtl/evt_gpio_rstsync.sv
module evt_gpio_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/evt_gpio_bufreg.sv
module evt_gpio_bufreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live_we,
  input  logic         buf_we,
  input  logic         tgl,
  input  logic [W-1:0] data,
  input  logic         commit,
  output logic [W-1:0] live_q,
  output logic         dirty_q
);
  logic [W-1:0] shadow_q, shadow_d, live_d;
  logic         mode_tgl_q, mode_tgl_d, dirty_d, upd_en;

  always_comb begin
    live_d     = live_q;
    shadow_d   = shadow_q;
    mode_tgl_d = mode_tgl_q;
    dirty_d    = dirty_q;
    if (live_we) begin
      live_d     = tgl ? (live_q ^ data) : data;
      shadow_d   = live_d;
      mode_tgl_d = 1'b0;
      dirty_d    = 1'b0;
    end else if (dirty_q) begin
      if (commit) begin
        live_d  = mode_tgl_q ? (live_q ^ shadow_q) : shadow_q;
        dirty_d = 1'b0;
      end
    end else if (buf_we) begin
      shadow_d   = data;
      mode_tgl_d = tgl;
      dirty_d    = 1'b1;
    end
  end

  assign upd_en = live_we | buf_we | commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= '0;
      shadow_q   <= '0;
      mode_tgl_q <= 1'b0;
      dirty_q    <= 1'b0;
    end else if (upd_en) begin
      live_q     <= live_d;
      shadow_q   <= shadow_d;
      mode_tgl_q <= mode_tgl_d;
      dirty_q    <= dirty_d;
    end
  end
endmodule

// File: rtl/evt_gpio_insample.sv
module evt_gpio_insample
  import evt_gpio_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter int unsigned SHIFT_PIN = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         ev1,
  input  logic [W-1:0] pad_in,
  input  logic         rd_buf,
  output logic [W-1:0] in_q,
  output logic         wake_q,
  output logic         stall
);
  logic [W-1:0] in_d;
  logic         in_en, pin0_q, wake_d, fresh_q, fresh_d;

  always_comb begin
    in_d  = in_q;
    in_en = 1'b0;
    unique case (in_mode_e'(mode))
      IN_FOLLOW: begin in_d = pad_in; in_en = 1'b1; end
      IN_LATCH:  begin in_d = pad_in; in_en = ev1;  end
      IN_SHIFT:  begin in_d = {in_q[W-2:0], pad_in[SHIFT_PIN]}; in_en = ev1; end
      default:   begin in_d = in_q;   in_en = 1'b0; end
    endcase
    wake_d  = (in_mode_e'(mode) == IN_FOLLOW) && (pad_in[0] != pin0_q);
    fresh_d = rd_buf & ev1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else if (in_en) in_q <= in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin0_q  <= 1'b0;
      wake_q  <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      pin0_q  <= pad_in[0];
      wake_q  <= wake_d;
      fresh_q <= fresh_d;
    end
  end

  assign stall = rd_buf & ~fresh_q;
endmodule

// File: rtl/evt_gpio_ctrl.sv
module evt_gpio_ctrl
  import evt_gpio_pkg::*;
#(
  parameter int unsigned W         = NPINS,
  parameter int unsigned SHIFT_PIN = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         wr_stall,
  output logic         dir_dirty,
  output logic         out_dirty,
  input  logic         ev0,
  input  logic         ev1,
  input  logic [1:0]   in_mode,
  input  logic         in_rd_buf,
  output logic         in_stall,
  output logic [W-1:0] in_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         wake
);
  localparam int unsigned NREG = 2;

  logic rst_sync_n;
  logic is_buf, is_tgl;
  logic [NREG-1:0] hit, dirty;
  logic [W-1:0]    live [NREG];

  evt_gpio_rstsync #(.STAGES(2)) i_rstsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign is_buf = wr_sel[SEL_BUF_BIT];
  assign is_tgl = wr_sel[SEL_TGL_BIT];

  // index 0: output enables, index 1: output values
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = wr_en && (wr_sel[SEL_VAL_BIT] == 1'(g));
    evt_gpio_bufreg #(.W(W)) i_bufreg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .live_we (hit[g] & ~is_buf),
      .buf_we  (hit[g] & is_buf),
      .tgl     (is_tgl),
      .data    (wr_data),
      .commit  (ev0),
      .live_q  (live[g]),
      .dirty_q (dirty[g])
    );
  end

  assign pad_oe    = live[0];
  assign pad_out   = live[1];
  assign dir_dirty = dirty[0];
  assign out_dirty = dirty[1];
  assign wr_stall  = |(hit & dirty) & is_buf;

  evt_gpio_insample #(.W(W), .SHIFT_PIN(SHIFT_PIN)) i_insample (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode   (in_mode),
    .ev1    (ev1),
    .pad_in (pad_in),
    .rd_buf (in_rd_buf),
    .in_q   (in_data),
    .wake_q (wake),
    .stall  (in_stall)
  );
endmodule

// File: rtl/evt_gpio_chk.sv
module evt_gpio_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_sel,
  input logic         wr_stall,
  input logic         dir_dirty,
  input logic         out_dirty,
  input logic         ev0,
  input logic         ev1,
  input logic [1:0]   in_mode,
  input logic         in_rd_buf,
  input logic         in_stall,
  input logic [W-1:0] in_data,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic         wake
);
  // R3: a commit with no competing live write empties the value buffer
  a_r3_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev0 && out_dirty && !(wr_en && wr_sel[2:1] == 2'b01)) |=> !out_dirty);

  // R4: a buffered write to a pending buffer is stalled
  a_r4_stall_on_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[2] && (wr_sel[1] ? out_dirty : dir_dirty)) |-> wr_stall);

  // R4: while stalled and no commit, the pads do not move
  a_r4_pins_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stall && !ev0) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R7: latch mode holds the input register between event B pulses
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == 2'd1 && !ev1) |=> $stable(in_data));

  // R9: hold mode freezes the input register
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == 2'd3) |=> $stable(in_data));

  // R10: no wake pulse outside follow mode
  a_r10_wake_follow_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode != 2'd0) |=> !wake);

  // R11: the input stall only appears under a synchronised read request
  a_r11_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |-> in_rd_buf);
endmodule

bind evt_gpio_ctrl evt_gpio_chk #(.W(W)) i_chk (.*);

// File: tb/test_evt_gpio_ctrl.sv
`timescale 1ns/1ps
module test_evt_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        wr_stall, dir_dirty, out_dirty;
  logic        ev0 = 1'b0, ev1 = 1'b0;
  logic [1:0]  in_mode = 2'd0;
  logic        in_rd_buf = 1'b0;
  logic        in_stall;
  logic [15:0] in_data, pad_out, pad_oe;
  logic [15:0] pad_in = '0;
  logic        wake;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  evt_gpio_ctrl i_evt_gpio_ctrl (.*);

  // kind[54:53] 0 live,1 buffered,2 ev0 | sel | data | exp_oe | exp_out | exp dir_dirty | exp out_dirty
  localparam logic [54:0] VEC [12] = '{
    {2'd0, 3'd0, 16'h00FF, 16'h00FF, 16'h0000, 1'b0, 1'b0},
    {2'd0, 3'd2, 16'h0F0F, 16'h00FF, 16'h0F0F, 1'b0, 1'b0},
    {2'd0, 3'd3, 16'h00FF, 16'h00FF, 16'h0FF0, 1'b0, 1'b0},
    {2'd0, 3'd1, 16'hFFFF, 16'hFF00, 16'h0FF0, 1'b0, 1'b0},
    {2'd1, 3'd6, 16'h1234, 16'hFF00, 16'h0FF0, 1'b0, 1'b1},
    {2'd2, 3'd0, 16'h0000, 16'hFF00, 16'h1234, 1'b0, 1'b0},
    {2'd1, 3'd7, 16'h0001, 16'hFF00, 16'h1234, 1'b0, 1'b1},
    {2'd1, 3'd4, 16'h0F0F, 16'hFF00, 16'h1234, 1'b1, 1'b1},
    {2'd2, 3'd0, 16'h0000, 16'h0F0F, 16'h1235, 1'b0, 1'b0},
    {2'd1, 3'd5, 16'hF000, 16'h0F0F, 16'h1235, 1'b1, 1'b0},
    {2'd0, 3'd0, 16'h0003, 16'h0003, 16'h1235, 1'b0, 1'b0},
    {2'd2, 3'd0, 16'h0000, 16'h0003, 16'h1235, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse0();
    @(negedge clk); ev0 = 1'b1;
    @(negedge clk); ev0 = 1'b0;
  endtask

  task automatic pulse1();
    @(negedge clk); ev1 = 1'b1;
    @(negedge clk); ev1 = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pad_oe, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 out after release", pad_out, 16'h0);
    check("R1 flags", {12'h0, dir_dirty, out_dirty, wake, wr_stall}, 16'h0);
    check("R1 in_data", in_data, 16'h0);

    // R2 R3 R5: table of register operations
    in_mode = 2'd3;
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][54:53] == 2'd2) pulse0();
      else do_write(VEC[i][52:50], VEC[i][49:34]);
      check($sformatf("R2/R3/R5 vec%0d oe", i), pad_oe, VEC[i][33:18]);
      check($sformatf("R2/R3/R5 vec%0d out", i), pad_out, VEC[i][17:2]);
      check($sformatf("R3 vec%0d dirty", i), {14'h0, dir_dirty, out_dirty}, {14'h0, VEC[i][1:0]});
    end

    // R4: stalled buffered write survives the commit
    do_write(3'd6, 16'hAAAA);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd6; wr_data = 16'h5555;
    #0.1;
    check("R4 stall raised", {15'h0, wr_stall}, 16'h1);
    repeat (3) @(negedge clk);
    check("R4 pins held", pad_out, 16'h1235);
    check("R4 still stalled", {15'h0, wr_stall}, 16'h1);
    ev0 = 1'b1;
    @(negedge clk);
    ev0 = 1'b0;
    check("R4 first commit", pad_out, 16'hAAAA);
    check("R4 stall released", {15'h0, wr_stall}, 16'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R4 late write pending", {15'h0, out_dirty}, 16'h1);
    pulse0();
    check("R4 second commit", pad_out, 16'h5555);

    // R5: live write wins over same-cycle commit
    do_write(3'd6, 16'h00F0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = 16'h0F00; ev0 = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ev0 = 1'b0;
    check("R5 live beats commit", pad_out, 16'h0F00);
    check("R5 dirty cleared", {15'h0, out_dirty}, 16'h0);
    pulse0();
    check("R5 later commit inert", pad_out, 16'h0F00);

    // R6: follow mode
    in_mode = 2'd0; pad_in = 16'hABCD;
    @(negedge clk);
    check("R6 follow", in_data, 16'hABCD);

    // R7: latch mode
    in_mode = 2'd1; pad_in = 16'h1111;
    repeat (3) @(negedge clk);
    check("R7 holds without ev1", in_data, 16'hABCD);
    pulse1();
    check("R7 latches on ev1", in_data, 16'h1111);

    // R8: shift mode, pin 1 enters bit 0
    in_mode = 2'd2; pad_in = 16'h0002;
    @(negedge clk);
    check("R8 no shift without ev1", in_data, 16'h1111);
    pulse1();
    check("R8 shift one", in_data, 16'h2223);
    pad_in = 16'hFFFD;
    pulse1();
    check("R8 shift zero", in_data, 16'h4446);

    // R9: hold mode
    in_mode = 2'd3; pad_in = 16'hFFFF;
    pulse1();
    check("R9 hold", in_data, 16'h4446);

    // R10: wake pulse
    in_mode = 2'd0; pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    check("R10 quiet", {15'h0, wake}, 16'h0);
    pad_in = 16'h0001;
    @(negedge clk);
    check("R10 pulse", {15'h0, wake}, 16'h1);
    @(negedge clk);
    check("R10 one cycle", {15'h0, wake}, 16'h0);
    in_mode = 2'd1;
    @(negedge clk);
    pad_in = 16'h0000;
    @(negedge clk);
    check("R10 no wake in latch mode", {15'h0, wake}, 16'h0);

    // R11: synchronised input read
    in_rd_buf = 1'b1;
    pad_in = 16'hBEEF;
    #0.1;
    check("R11 stall on request", {15'h0, in_stall}, 16'h1);
    repeat (3) @(negedge clk);
    check("R11 still stalled", {15'h0, in_stall}, 16'h1);
    ev1 = 1'b1;
    @(negedge clk);
    ev1 = 1'b0;
    check("R11 released", {15'h0, in_stall}, 16'h0);
    check("R11 fresh data", in_data, 16'hBEEF);
    in_rd_buf = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule